// File: doc/BRIEF.md
# Accumulating Row-Serial Top-Four Selector

This block picks the four strongest candidate objects out of a two-dimensional grid that is far too wide to sort in one pass. The grid arrives one row per clock. All columns of a row come in together as a flat vector of energies. Each candidate is given a position tag on entry: its row is the number of rows accepted since the event began, and its column is its lane number.

A pipelined reduction tree cuts each row down to its own best four. That short list is then merged with the four survivors kept from the earlier rows of the same event. Because each row needs only one small merge, a new row can be accepted on every clock. The only latency added after the last row is the depth of one row reduction plus that final merge.

An event opens with a start pulse. After the final row has been merged, the four winners appear ranked on the outputs together with a one-cycle valid strobe. The outputs then hold their values until the next result. By default the grid is 40 rows by 36 columns of 10-bit energies. Each row step therefore reduces 36 new candidates plus 4 carried survivors to 4.

Top module: `top4_sorter`

## Requirements
- R1: While reset is high and after it is released, `out_valid` is 0. Every output slot reads energy 0, row 0 and column 0 until the first result.
- R2: A candidate in lane c (bits `[c*E_W +: E_W]` of `row_energy`) carries column tag c. Its row tag is the number of rows accepted in the current event before it, so the first row is 0. Both tags appear with the energy in the output slot that the candidate wins.
- R3: The four outputs are the four highest energies among all N_ROWS×N_COLS candidates of the event. Slot 0 (lowest bits of each output bus) is the best and slot 3 the fourth best.
- R4: When energies are equal, the lower row index ranks higher. When rows are also equal, the lower column index ranks higher. Zero-energy candidates are ranked by the same rule.
- R5: `evt_start` clears the survivors and restarts the row count. Rows of an earlier, unfinished event cannot appear in the result. If `evt_start` coincides with `row_valid`, that row is row 0. Otherwise the next valid row is row 0.
- R6: One row is accepted on every clock in which `row_valid` is high. Idle cycles between the rows of an event do not change the result.
- R7: `out_valid` is a single-cycle pulse. It rises exactly $clog2(N_COLS)+2 rising edges after the edge that accepts row N_ROWS-1, counting that accepting edge as the first. There is exactly one pulse per completed event.
- R8: The outputs hold their values in every cycle in which `out_valid` is low.
- R9: Rows are ignored, and produce no pulse, in two cases: rows that arrive after reset before any `evt_start`, and rows beyond the N_ROWS-th of an event before the next `evt_start`.
- R10: An event may start in the cycle right after the last row of the previous event. Both events then produce correct, separate results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_start | input | 1 | Opens a new event |
| row_valid | input | 1 | Row present on `row_energy` |
| row_energy | input | N_COLS*E_W | Energies of one row, lane c at `[c*E_W +: E_W]` |
| out_valid | output | 1 | One-cycle result strobe |
| out_energy | output | TOP_N*E_W | Ranked winner energies, slot k at `[k*E_W +: E_W]` |
| out_row | output | TOP_N*$clog2(N_ROWS) | Row tags of the winners |
| out_col | output | TOP_N*$clog2(N_COLS) | Column tags of the winners |

## Verification
The assertions check several properties on every cycle:
- the result strobe never lasts two cycles;
- the strobe appears exactly at the fixed latency after the final-row acceptance;
- the four presented winners are strictly ranked by energy and then by tag;
- the outputs do not move between strobes.

Only the bench scenarios can show that the winners are the true best four of the whole grid. The same applies to the following:
- that tags match their origin;
- that abandoned or surplus rows and rows before any start are kept out;
- that idle gaps and back-to-back events leave the results intact.

The bench checks all of these against a brute-force selection computed over a small grid.

// File: rtl/top4_pkg.sv
package top4_pkg;

    // Pipeline control travelling alongside each row
    typedef struct packed {
        logic vld;   // a row occupies this stage
        logic last;  // the row is the final one of its event
        logic clr;   // survivors must be cleared before this stage merges
    } ctl_t;

    localparam int DEF_ROWS = 40;
    localparam int DEF_COLS = 36;
    localparam int DEF_EW   = 10;
    localparam int DEF_TOPN = 4;

    // Width of one ranking key: {present, energy, ~row, ~col}
    function automatic int key_width(input int ew, input int rw, input int cw);
        return 1 + ew + rw + cw;
    endfunction

endpackage

// File: rtl/top4_merge.sv
// Merges two ranked lists of K keys (slot 0 best) into the best K.
// A larger key ranks higher; on equal keys list a ranks first.
module top4_merge #(
    parameter int K = 4,
    parameter int W = 8
) (
    input  logic [K*W-1:0] a_list,
    input  logic [K*W-1:0] b_list,
    output logic [K*W-1:0] y_list
);

    always_comb begin
        y_list = '0;
        for (int i = 0; i < K; i++) begin
            int pos;
            pos = i;
            for (int j = 0; j < K; j++) begin
                if (b_list[j*W +: W] > a_list[i*W +: W]) pos++;
            end
            if (pos < K) y_list[pos*W +: W] = a_list[i*W +: W];
        end
        for (int j = 0; j < K; j++) begin
            int pos;
            pos = j;
            for (int i = 0; i < K; i++) begin
                if (!(b_list[j*W +: W] > a_list[i*W +: W])) pos++;
            end
            if (pos < K) y_list[pos*W +: W] = b_list[j*W +: W];
        end
    end

endmodule

// File: rtl/top4_row_tree.sv
// Pipelined reduction of one row of keys to its best K, one register per level.
module top4_row_tree
    import top4_pkg::*;
#(
    parameter int N_LANES = 36,
    parameter int K       = 4,
    parameter int W       = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  ctl_t                 in_ctl,
    input  logic [N_LANES*W-1:0] in_lanes,
    output ctl_t                 out_ctl,
    output logic [K*W-1:0]       out_list
);

    localparam int LEVELS = (N_LANES > 1) ? $clog2(N_LANES) : 0;
    localparam int SPAN   = 1 << LEVELS;
    localparam int LW     = K * W;

    // Padding lanes are zero keys, which rank below every present candidate
    logic [SPAN*W-1:0] lanes_pad;
    assign lanes_pad = (SPAN*W)'(in_lanes);

    genvar l, i;
    generate
        for (l = 0; l <= LEVELS; l++) begin : g_lvl
            localparam int NODES = SPAN >> l;
            logic [NODES*LW-1:0] nd;
            ctl_t                ct;

            if (l == 0) begin : g_leaf
                always_ff @(posedge clk) begin
                    if (rst) begin
                        ct <= '0;
                        nd <= '0;
                    end else begin
                        ct <= in_ctl;
                        for (int n = 0; n < NODES; n++) begin
                            nd[n*LW +: LW] <= LW'(lanes_pad[n*W +: W]);
                        end
                    end
                end
            end else begin : g_merge
                logic [NODES*LW-1:0] mg;
                for (i = 0; i < NODES; i++) begin : g_node
                    top4_merge #(.K(K), .W(W)) u_mrg (
                        .a_list (g_lvl[l-1].nd[(2*i)*LW +: LW]),
                        .b_list (g_lvl[l-1].nd[(2*i+1)*LW +: LW]),
                        .y_list (mg[i*LW +: LW])
                    );
                end
                always_ff @(posedge clk) begin
                    if (rst) begin
                        ct <= '0;
                        nd <= '0;
                    end else begin
                        ct <= g_lvl[l-1].ct;
                        nd <= mg;
                    end
                end
            end
        end
    endgenerate

    assign out_ctl  = g_lvl[LEVELS].ct;
    assign out_list = g_lvl[LEVELS].nd;

endmodule

// File: rtl/top4_accum.sv
// Survivor store: merges each row's best K into the running best K.
module top4_accum
    import top4_pkg::*;
#(
    parameter int K = 4,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  ctl_t           in_ctl,
    input  logic [K*W-1:0] in_list,
    output logic           out_valid,
    output logic [K*W-1:0] out_list
);

    logic [K*W-1:0] surv;
    logic [K*W-1:0] base;
    logic [K*W-1:0] mrg;

    // A clear marker aligned with a row replaces the survivors before merging
    assign base = in_ctl.clr ? '0 : surv;

    top4_merge #(.K(K), .W(W)) u_mrg (
        .a_list (base),
        .b_list (in_list),
        .y_list (mrg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            surv      <= '0;
            out_valid <= 1'b0;
            out_list  <= '0;
        end else begin
            out_valid <= in_ctl.vld && in_ctl.last;
            if (in_ctl.vld) begin
                surv <= mrg;
                if (in_ctl.last) out_list <= mrg;
            end else if (in_ctl.clr) begin
                surv <= '0;
            end
        end
    end

endmodule

// File: rtl/top4_sorter.sv
module top4_sorter
    import top4_pkg::*;
#(
    parameter int N_ROWS = DEF_ROWS,
    parameter int N_COLS = DEF_COLS,
    parameter int E_W    = DEF_EW,
    parameter int TOP_N  = DEF_TOPN,
    localparam int RW    = $clog2(N_ROWS),
    localparam int CW    = $clog2(N_COLS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   evt_start,
    input  logic                   row_valid,
    input  logic [N_COLS*E_W-1:0]  row_energy,
    output logic                   out_valid,
    output logic [TOP_N*E_W-1:0]   out_energy,
    output logic [TOP_N*RW-1:0]    out_row,
    output logic [TOP_N*CW-1:0]    out_col
);

    localparam int W   = key_width(E_W, RW, CW);
    localparam int RCW = $clog2(N_ROWS + 1);

    // ---------------- row admission and tagging ----------------
    logic [RCW-1:0] row_cnt;   // equals N_ROWS when no event is open
    logic [RW-1:0]  row_idx;
    logic           accept;
    logic           acc_last;

    assign row_idx  = evt_start ? '0 : row_cnt[RW-1:0];
    assign accept   = row_valid && (evt_start || (row_cnt < RCW'(N_ROWS)));
    assign acc_last = accept && (row_idx == RW'(N_ROWS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            row_cnt <= RCW'(N_ROWS);
        end else if (accept) begin
            row_cnt <= RCW'(row_idx) + RCW'(1);
        end else if (evt_start) begin
            row_cnt <= '0;
        end
    end

    logic [N_COLS*W-1:0] lane_keys;
    genvar c;
    generate
        for (c = 0; c < N_COLS; c++) begin : g_lane
            assign lane_keys[c*W +: W] =
                {1'b1, row_energy[c*E_W +: E_W], ~row_idx, ~CW'(c)};
        end
    endgenerate

    ctl_t front_ctl;
    always_comb begin
        front_ctl.vld  = accept;
        front_ctl.last = acc_last;
        front_ctl.clr  = evt_start;
    end

    // ---------------- row reduction and accumulation ----------------
    ctl_t                 tree_ctl;
    logic [TOP_N*W-1:0]   tree_list;
    logic [TOP_N*W-1:0]   res_list;

    top4_row_tree #(.N_LANES(N_COLS), .K(TOP_N), .W(W)) u_tree (
        .clk      (clk),
        .rst      (rst),
        .in_ctl   (front_ctl),
        .in_lanes (lane_keys),
        .out_ctl  (tree_ctl),
        .out_list (tree_list)
    );

    top4_accum #(.K(TOP_N), .W(W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .in_ctl    (tree_ctl),
        .in_list   (tree_list),
        .out_valid (out_valid),
        .out_list  (res_list)
    );

    // ---------------- key decode to ports ----------------
    genvar k;
    generate
        for (k = 0; k < TOP_N; k++) begin : g_out
            logic [W-1:0] slot;
            assign slot = res_list[k*W +: W];
            assign out_energy[k*E_W +: E_W] = slot[W-1] ? slot[W-2 -: E_W] : '0;
            assign out_row[k*RW +: RW]      = slot[W-1] ? ~slot[CW+RW-1 -: RW] : '0;
            assign out_col[k*CW +: CW]      = slot[W-1] ? ~slot[CW-1:0] : '0;
        end
    endgenerate

endmodule

// File: rtl/top4_sorter_chk.sv
module top4_sorter_chk #(
    parameter int N_ROWS = 40,
    parameter int N_COLS = 36,
    parameter int E_W    = 10,
    parameter int TOP_N  = 4,
    localparam int RW    = $clog2(N_ROWS),
    localparam int CW    = $clog2(N_COLS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 acc_last,
    input logic                 out_valid,
    input logic [TOP_N*E_W-1:0] out_energy,
    input logic [TOP_N*RW-1:0]  out_row,
    input logic [TOP_N*CW-1:0]  out_col
);

    localparam int LAT = $clog2(N_COLS) + 2;

    // History of final-row acceptances, one bit per edge
    logic [LAT-1:0] last_hist;
    always_ff @(posedge clk) begin
        if (rst) last_hist <= '0;
        else     last_hist <= {last_hist[LAT-2:0], acc_last};
    end

    // R7
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R7
    result_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == last_hist[LAT-1]);

    // R8
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_energy) && $stable(out_row) && $stable(out_col)));

    genvar k;
    generate
        for (k = 0; k + 1 < TOP_N; k++) begin : g_rank
            // R4
            rank_order_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid |->
                ({out_energy[k*E_W +: E_W], ~out_row[k*RW +: RW], ~out_col[k*CW +: CW]} >
                 {out_energy[(k+1)*E_W +: E_W], ~out_row[(k+1)*RW +: RW], ~out_col[(k+1)*CW +: CW]}));
        end
    endgenerate

endmodule

bind top4_sorter top4_sorter_chk #(
    .N_ROWS (N_ROWS),
    .N_COLS (N_COLS),
    .E_W    (E_W),
    .TOP_N  (TOP_N)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_last   (acc_last),
    .out_valid  (out_valid),
    .out_energy (out_energy),
    .out_row    (out_row),
    .out_col    (out_col)
);

// File: tb/top4_sorter_tb.sv
module top4_sorter_tb;

    localparam int NR  = 6;
    localparam int NC  = 5;
    localparam int EW  = 4;
    localparam int K   = 4;
    localparam int RW  = $clog2(NR);
    localparam int CW  = $clog2(NC);
    localparam int LAT = $clog2(NC) + 2;
    localparam int MAXR = 128;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              evt_start = 1'b0;
    logic              row_valid = 1'b0;
    logic [NC*EW-1:0]  row_energy = '0;
    logic              out_valid;
    logic [K*EW-1:0]   out_energy;
    logic [K*RW-1:0]   out_row;
    logic [K*CW-1:0]   out_col;

    always #2 clk = ~clk;   // 250 MHz

    top4_sorter #(.N_ROWS(NR), .N_COLS(NC), .E_W(EW), .TOP_N(K)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .evt_start  (evt_start),
        .row_valid  (row_valid),
        .row_energy (row_energy),
        .out_valid  (out_valid),
        .out_energy (out_energy),
        .out_row    (out_row),
        .out_col    (out_col)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    int g [NR][NC];
    int exp_e [MAXR][K], exp_r [MAXR][K], exp_c [MAXR][K], exp_cyc [MAXR];
    int res_e [MAXR][K], res_r [MAXR][K], res_c [MAXR][K], res_cyc [MAXR];
    int exp_n = 0, res_n = 0, cmp_base = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && out_valid && res_n < MAXR) begin
            for (int k = 0; k < K; k++) begin
                res_e[res_n][k] = int'(out_energy[k*EW +: EW]);
                res_r[res_n][k] = int'(out_row[k*RW +: RW]);
                res_c[res_n][k] = int'(out_col[k*CW +: CW]);
            end
            res_cyc[res_n] = cyc;
            res_n++;
        end
    end

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Brute-force ranking of the current grid (scan order gives the tie rule)
    task automatic record_expected();
        bit taken [NR][NC];
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) taken[r][c] = 0;
        for (int k = 0; k < K; k++) begin
            int be = -1, br = 0, bc = 0;
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NC; c++)
                    if (!taken[r][c] && g[r][c] > be) begin
                        be = g[r][c]; br = r; bc = c;
                    end
            taken[br][bc] = 1;
            exp_e[exp_n][k] = be;
            exp_r[exp_n][k] = br;
            exp_c[exp_n][k] = bc;
        end
        exp_cyc[exp_n] = cyc + LAT - 1;
        exp_n++;
    endtask

    task automatic put_row(input int r, input bit st);
        for (int c = 0; c < NC; c++) row_energy[c*EW +: EW] = EW'(g[r][c]);
        row_valid = 1'b1;
        evt_start = st;
        @(negedge clk);
        row_valid = 1'b0;
        evt_start = 1'b0;
    endtask

    task automatic put_raw(input int v, input bit st);
        for (int c = 0; c < NC; c++) row_energy[c*EW +: EW] = EW'(v);
        row_valid = 1'b1;
        evt_start = st;
        @(negedge clk);
        row_valid = 1'b0;
        evt_start = 1'b0;
    endtask

    task automatic send_event(input int gapmax, input bit start_alone);
        if (start_alone) begin
            evt_start = 1'b1;
            @(negedge clk);
            evt_start = 1'b0;
        end
        for (int r = 0; r < NR; r++) begin
            put_row(r, !start_alone && r == 0);
            if (gapmax > 0 && r < NR - 1)
                repeat ($urandom_range(gapmax, 0)) @(negedge clk);
        end
        record_expected();
    endtask

    task automatic settle();
        repeat (LAT + 4) @(negedge clk);
    endtask

    task automatic compare_all(input string req);
        chk("R7", res_n, exp_n);
        for (int i = cmp_base; i < exp_n && i < res_n; i++) begin
            chk("R7", res_cyc[i], exp_cyc[i]);
            for (int k = 0; k < K; k++) begin
                chk(req, res_e[i][k], exp_e[i][k]);
                chk("R2", res_r[i][k], exp_r[i][k]);
                chk("R2", res_c[i][k], exp_c[i][k]);
            end
        end
        if (res_n != exp_n) res_n = exp_n;
        cmp_base = exp_n;
    endtask

    task automatic fill(input int mode);
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++)
                case (mode)
                    0: g[r][c] = 7;
                    1: g[r][c] = 0;
                    2: g[r][c] = int'($urandom_range(14, 0));
                    default: g[r][c] = int'($urandom_range(15, 0));
                endcase
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", int'(out_valid), 0);
        chk("R1", int'(out_energy), 0);
        chk("R1", int'(out_row), 0);
        chk("R1", int'(out_col), 0);

        // R9: rows before any event start are ignored
        for (int r = 0; r < NR + 2; r++) put_raw(15, 0);
        settle();
        compare_all("R9");
        chk("R1", int'(out_energy), 0);

        // R4: all-equal and all-zero grids rank purely by tags
        fill(0); send_event(0, 0); settle(); compare_all("R4");
        fill(1); send_event(0, 0); settle(); compare_all("R4");

        // R3 / R6 / R5: random sweep with gaps and detached start pulses
        for (int e = 0; e < 30; e++) begin
            fill(3);
            if (e % 3 == 2) begin
                send_event(0, 1); settle(); compare_all("R5");
            end else if (e % 2 == 1) begin
                send_event(3, 0); settle(); compare_all("R6");
            end else begin
                send_event(0, 0); settle(); compare_all("R3");
            end
        end

        // R5: an abandoned partial event with maximal energies must vanish
        put_raw(15, 1);
        put_raw(15, 0);
        put_raw(15, 0);
        fill(2); send_event(0, 0); settle(); compare_all("R5");

        // R9 / R8: surplus rows after the last one change nothing
        for (int i = 0; i < 3; i++) put_raw(15, 0);
        settle();
        compare_all("R9");
        for (int k = 0; k < K; k++) begin
            chk("R8", int'(out_energy[k*EW +: EW]), exp_e[exp_n-1][k]);
            chk("R8", int'(out_row[k*RW +: RW]), exp_r[exp_n-1][k]);
            chk("R8", int'(out_col[k*CW +: CW]), exp_c[exp_n-1][k]);
        end

        // R10: back-to-back events
        for (int e = 0; e < 3; e++) begin
            fill(3); send_event(0, 0);
            fill(3); send_event(0, 0);
            settle();
            compare_all("R10");
        end

        summary();
    end

endmodule